// File: doc/BRIEF.md
# CAN Triple Transmit Buffer Scheduler

This block holds three outgoing CAN message buffers and decides which of them is handed to the bit-level transmitter. Each buffer stores a 13-byte frame image (four identifier bytes, eight data bytes and one length byte), an 8-bit local priority and a 16-bit time stamp. The CPU reaches the storage through one shared byte window. A one-hot selection register chooses which buffer the window maps.

A buffer whose empty flag is set belongs to the CPU. To queue a buffer, software selects it, fills it through the window, and then clears its empty flag. The scheduler offers the best ready buffer to the transmitter. A win event locks that buffer. A lost-arbitration event unlocks it and leaves it pending. A frame-complete event returns the buffer to the CPU: it sets the empty flag, latches the free-running timer into the buffer's time stamp, and pulses a per-buffer done output. In the cycle after completion, the next ready buffer is already offered, so a stream of frames never waits for software.

Top module: `can_txbuf_sched`

## Requirements
- R1: After reset all three empty flags read 1, the selection reads 000, txReq and txDone are 0, and the window reads 0x00.
- R2: A selection write keeps only the lowest-indexed bit that is both written as 1 and has its empty flag set. If no written bit qualifies, the selection becomes 000.
- R3: Window addresses 0-12 are the frame bytes, 13 is the priority, 14 is the time stamp high byte and 15 is the low byte. Reads and writes reach only the selected buffer. With no selection, writes are ignored and reads return 0x00. Writes to 14 and 15 are ignored.
- R4: Clearing a buffer's empty flag through flagClrEn/flagClrMask makes it ready. From the next cycle, txReq is 1 and txIdx/txFrame present that buffer. txFrame byte k occupies bits 8k+7:8k.
- R5: Among ready, unlocked candidates, the buffer with the numerically lowest priority is offered. Ties go to the lowest index.
- R6: evWin while txReq is 1 and nothing is locked locks the offered buffer. While locked, txIdx does not change, even if a better buffer becomes ready.
- R7: evLost while locked releases the lock and leaves the buffer's empty flag at 0, so that buffer competes again from the next cycle.
- R8: evDone while locked sets that buffer's empty flag and latches timeIn, as sampled on that edge, into its time stamp. txDone is then 1 on that buffer's bit for exactly one cycle.
- R9: In the cycle after a completion, the best remaining ready buffer is offered without any CPU action.
- R10: evDone or evLost with nothing locked changes no flag, lock or txDone.
- R11: The selection reads back 0 for a buffer whose empty flag is 0, and the window then maps nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selWrEn | input | 1 | Selection register write strobe |
| selWrData | input | 3 | Requested selection mask |
| selRd | output | 3 | Effective one-hot selection |
| flagClrEn | input | 1 | Empty flag clear strobe |
| flagClrMask | input | 3 | Buffers to mark ready |
| emptyFlags | output | 3 | Per-buffer empty flags |
| winWrEn | input | 1 | Window write strobe |
| winAddr | input | 4 | Window byte address |
| winWrData | input | 8 | Window write data |
| winRdData | output | 8 | Window read data |
| timeIn | input | 16 | Free-running timer value |
| txReq | output | 1 | A frame is offered to the transmitter |
| txIdx | output | 2 | Index of the offered buffer |
| txFrame | output | 104 | Frame image of the offered buffer |
| evWin | input | 1 | Transmitter won arbitration |
| evLost | input | 1 | Transmitter lost arbitration |
| evDone | input | 1 | Frame completed successfully |
| txDone | output | 3 | One-cycle per-buffer completion pulse |

## Verification
The assertions check four properties on every cycle. A locked buffer stays locked on the same index and keeps its empty flag at 0 until an event releases it. Completion always hands the buffer back to the CPU, and the done pulse is at most one-hot. The time stamp equals the timer value from the capture edge. The selection is never more than one-hot. Only the bench's scenarios can show the rest: which buffer wins for a given set of priorities, that a buffer loses its place after lost arbitration, that window traffic stays in the selected buffer, and that the next frame is offered right after completion.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam int NUM_BUF     = 3;
  localparam int IDX_W       = $clog2(NUM_BUF);
  localparam int FRAME_BYTES = 13;
  localparam int FRAME_W     = FRAME_BYTES * 8;
  localparam int PRIO_W      = 8;
  localparam int TS_W        = 16;
  localparam int ADDR_W      = 4;
  localparam int PRIO_ADDR   = FRAME_BYTES;
  localparam int TS_HI_ADDR  = FRAME_BYTES + 1;
  localparam int TS_LO_ADDR  = FRAME_BYTES + 2;

  typedef struct packed {
    logic [NUM_BUF-1:0] winWr;
    logic [NUM_BUF-1:0] rdSel;
    logic [NUM_BUF-1:0] tsCap;
    logic [IDX_W-1:0]   sendIdx;
  } strobes_t;

  function automatic logic [NUM_BUF-1:0] lowestBit(input logic [NUM_BUF-1:0] v);
    logic [NUM_BUF-1:0] r;
    r = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (v[i]) r = NUM_BUF'(1) << i;
    end
    return r;
  endfunction
endpackage

// File: rtl/txb_ctrl.sv
module txb_ctrl
  import txb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      selWrEn,
  input  logic [NUM_BUF-1:0]        selWrData,
  input  logic                      flagClrEn,
  input  logic [NUM_BUF-1:0]        flagClrMask,
  input  logic                      winWrEn,
  input  logic                      evWin,
  input  logic                      evLost,
  input  logic                      evDone,
  input  logic [NUM_BUF*PRIO_W-1:0] prioFlat,
  output logic [NUM_BUF-1:0]        emptyFlags,
  output logic [NUM_BUF-1:0]        selRd,
  output logic                      txReq,
  output logic [IDX_W-1:0]          txIdx,
  output logic [NUM_BUF-1:0]        txDone,
  output strobes_t                  st
);
  logic [NUM_BUF-1:0] emptyReg, emptyNext, selReg, lockHot;
  logic               lockValid, doneOk, lostOk, anyReady;
  logic [IDX_W-1:0]   lockIdx, pickIdx;
  logic [PRIO_W-1:0]  bestPrio;

  // Arbitration: lowest value wins, strict compare keeps ties at the lower index.
  always_comb begin
    pickIdx  = '0;
    bestPrio = '1;
    anyReady = 1'b0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (!emptyReg[i] && (!anyReady || prioFlat[i*PRIO_W +: PRIO_W] < bestPrio)) begin
        pickIdx  = IDX_W'(i);
        bestPrio = prioFlat[i*PRIO_W +: PRIO_W];
        anyReady = 1'b1;
      end
    end
  end

  assign doneOk  = lockValid && evDone;
  assign lostOk  = lockValid && evLost && !evDone;
  assign lockHot = NUM_BUF'(1) << lockIdx;
  assign txReq   = lockValid || anyReady;
  assign txIdx   = lockValid ? lockIdx : pickIdx;

  always_comb begin
    emptyNext = emptyReg;
    if (flagClrEn) emptyNext = emptyNext & ~flagClrMask;
    if (doneOk)    emptyNext = emptyNext | lockHot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emptyReg  <= '1;
      selReg    <= '0;
      lockValid <= 1'b0;
      lockIdx   <= '0;
      txDone    <= '0;
    end else begin
      emptyReg <= emptyNext;
      txDone   <= doneOk ? lockHot : '0;
      if (selWrEn) selReg <= lowestBit(selWrData & emptyReg);
      if (doneOk || lostOk) begin
        lockValid <= 1'b0;
      end else if (!lockValid && evWin && anyReady) begin
        lockValid <= 1'b1;
        lockIdx   <= pickIdx;
      end
    end
  end

  assign emptyFlags = emptyReg;
  assign selRd      = selReg & emptyReg;
  assign st.rdSel   = selRd;
  assign st.winWr   = winWrEn ? selRd : '0;
  assign st.tsCap   = doneOk ? lockHot : '0;
  assign st.sendIdx = txIdx;

  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selReg));
  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lockValid && !evDone && !evLost) |=> (lockValid && lockIdx == $past(lockIdx)));
  assert_lock_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    lockValid |-> !emptyReg[lockIdx]);
  assert_done_returns_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lockValid && evDone) |=> (emptyReg[$past(lockIdx)] && !lockValid));
  assert_done_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(txDone));
endmodule

// File: rtl/txb_data.sv
module txb_data
  import txb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  strobes_t                  st,
  input  logic [ADDR_W-1:0]         winAddr,
  input  logic [7:0]                winWrData,
  input  logic [TS_W-1:0]           timeIn,
  output logic [7:0]                winRdData,
  output logic [NUM_BUF*PRIO_W-1:0] prioFlat,
  output logic [FRAME_W-1:0]        txFrame
);
  logic [FRAME_W-1:0] frameFlat [NUM_BUF];
  logic [7:0]         byteOut   [NUM_BUF];

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic [FRAME_W-1:0] frameReg;
    logic [PRIO_W-1:0]  prioReg;
    logic [TS_W-1:0]    tsReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        frameReg <= '0;
        prioReg  <= '0;
        tsReg    <= '0;
      end else begin
        if (st.winWr[b]) begin
          if (int'(winAddr) < FRAME_BYTES) frameReg[{winAddr, 3'b000} +: 8] <= winWrData;
          else if (int'(winAddr) == PRIO_ADDR) prioReg <= winWrData;
        end
        if (st.tsCap[b]) tsReg <= timeIn;
      end
    end

    always_comb begin
      if (int'(winAddr) < FRAME_BYTES)      byteOut[b] = frameReg[{winAddr, 3'b000} +: 8];
      else if (int'(winAddr) == PRIO_ADDR)  byteOut[b] = prioReg;
      else if (int'(winAddr) == TS_HI_ADDR) byteOut[b] = tsReg[15:8];
      else                                  byteOut[b] = tsReg[7:0];
    end

    assign frameFlat[b]                       = frameReg;
    assign prioFlat[b*PRIO_W +: PRIO_W]       = prioReg;

    assert_ts_latch_R8: assert property (@(posedge clk) disable iff (!rstN)
      st.tsCap[b] |=> (tsReg == $past(timeIn)));
  end

  always_comb begin
    winRdData = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      if (st.rdSel[b]) winRdData = winRdData | byteOut[b];
    end
  end

  assign txFrame = (int'(st.sendIdx) < NUM_BUF) ? frameFlat[st.sendIdx] : '0;
endmodule

// File: rtl/can_txbuf_sched.sv
module can_txbuf_sched
  import txb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      selWrEn,
  input  logic [NUM_BUF-1:0]        selWrData,
  output logic [NUM_BUF-1:0]        selRd,
  input  logic                      flagClrEn,
  input  logic [NUM_BUF-1:0]        flagClrMask,
  output logic [NUM_BUF-1:0]        emptyFlags,
  input  logic                      winWrEn,
  input  logic [ADDR_W-1:0]         winAddr,
  input  logic [7:0]                winWrData,
  output logic [7:0]                winRdData,
  input  logic [TS_W-1:0]           timeIn,
  output logic                      txReq,
  output logic [IDX_W-1:0]          txIdx,
  output logic [FRAME_W-1:0]        txFrame,
  input  logic                      evWin,
  input  logic                      evLost,
  input  logic                      evDone,
  output logic [NUM_BUF-1:0]        txDone
);
  strobes_t                  st;
  logic [NUM_BUF*PRIO_W-1:0] prioFlat;

  txb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .selWrEn(selWrEn), .selWrData(selWrData),
    .flagClrEn(flagClrEn), .flagClrMask(flagClrMask), .winWrEn(winWrEn),
    .evWin(evWin), .evLost(evLost), .evDone(evDone), .prioFlat(prioFlat),
    .emptyFlags(emptyFlags), .selRd(selRd), .txReq(txReq), .txIdx(txIdx),
    .txDone(txDone), .st(st)
  );

  txb_data u_data (
    .clk(clk), .rstN(rstN), .st(st), .winAddr(winAddr), .winWrData(winWrData),
    .timeIn(timeIn), .winRdData(winRdData), .prioFlat(prioFlat), .txFrame(txFrame)
  );
endmodule

// File: tb/tb_can_txbuf_sched.sv
module tb_can_txbuf_sched;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         selWrEn = 1'b0, flagClrEn = 1'b0, winWrEn = 1'b0;
  logic [2:0]   selWrData = '0, flagClrMask = '0;
  logic [3:0]   winAddr = '0;
  logic [7:0]   winWrData = '0;
  logic [15:0]  timeIn = '0;
  logic         evWin = 1'b0, evLost = 1'b0, evDone = 1'b0;
  logic [2:0]   selRd, emptyFlags, txDone;
  logic [7:0]   winRdData;
  logic         txReq;
  logic [1:0]   txIdx;
  logic [103:0] txFrame;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  can_txbuf_sched dut (.*);

  // {prio0, prio1, prio2, expected winner}
  localparam logic [31:0] VEC [6] = '{
    {8'd10,  8'd20, 8'd30,  8'd0},
    {8'd30,  8'd20, 8'd10,  8'd2},
    {8'd5,   8'd5,  8'd9,   8'd0},
    {8'd9,   8'd4,  8'd4,   8'd1},
    {8'd255, 8'd0,  8'd255, 8'd1},
    {8'd7,   8'd7,  8'd7,   8'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic selWrite(input logic [2:0] m);
    selWrEn = 1'b1; selWrData = m; cyc(); selWrEn = 1'b0;
  endtask

  task automatic winWrite(input logic [3:0] a, input logic [7:0] d);
    winWrEn = 1'b1; winAddr = a; winWrData = d; cyc(); winWrEn = 1'b0;
  endtask

  task automatic winRead(input logic [3:0] a, output logic [7:0] d);
    winAddr = a; #1; d = winRdData;
  endtask

  task automatic flagClr(input logic [2:0] m);
    flagClrEn = 1'b1; flagClrMask = m; cyc(); flagClrEn = 1'b0;
  endtask

  task automatic pulseWin();  evWin = 1'b1;  cyc(); evWin = 1'b0;  endtask
  task automatic pulseLost(); evLost = 1'b1; cyc(); evLost = 1'b0; endtask
  task automatic pulseDone(); evDone = 1'b1; cyc(); evDone = 1'b0; endtask

  initial begin
    logic [7:0] rd;
    cyc(); cyc();
    rstN = 1'b1;
    cyc();

    // R1 reset state
    chk("R1 empty", 32'(emptyFlags), 32'h7);
    chk("R1 sel", 32'(selRd), 0);
    chk("R1 req", 32'(txReq), 0);
    chk("R1 done", 32'(txDone), 0);
    winRead(4'd0, rd);
    chk("R1 window", 32'(rd), 0);

    // R2 selection masking
    selWrite(3'b110);
    chk("R2 lowest set bit", 32'(selRd), 32'h2);
    selWrite(3'b000);
    chk("R2 none", 32'(selRd), 0);

    // R3 window isolation
    selWrite(3'b001); winWrite(4'd0, 8'h11); winWrite(4'd12, 8'h1C);
    selWrite(3'b010); winWrite(4'd0, 8'h22);
    winRead(4'd0, rd);
    chk("R3 buf1 byte0", 32'(rd), 32'h22);
    selWrite(3'b001);
    winRead(4'd0, rd);
    chk("R3 buf0 byte0", 32'(rd), 32'h11);
    winRead(4'd12, rd);
    chk("R3 buf0 byte12", 32'(rd), 32'h1C);
    selWrite(3'b000); winWrite(4'd0, 8'hEE);
    winRead(4'd0, rd);
    chk("R3 no selection reads zero", 32'(rd), 0);
    selWrite(3'b001);
    winRead(4'd0, rd);
    chk("R3 unselected write ignored", 32'(rd), 32'h11);

    // R5 priority table walk
    foreach (VEC[v]) begin
      for (int b = 0; b < 3; b++) begin
        selWrite(3'(1 << b));
        winWrite(4'd13, VEC[v][31 - 8*b -: 8]);
        winWrite(4'd0, 8'hA0 + 8'(b));
      end
      flagClr(3'b111);
      chk("R5 winner index", 32'(txIdx), 32'(VEC[v][7:0]));
      chk("R5 winner frame", 32'(txFrame[7:0]), 32'(8'hA0 + VEC[v][7:0]));
      for (int k = 0; k < 3; k++) begin
        pulseWin(); pulseDone();
      end
      chk("R9 drained all", 32'(emptyFlags), 32'h7);
    end

    // R4 single buffer ready (prios now 7,7,7)
    flagClr(3'b100);
    chk("R4 req", 32'(txReq), 1);
    chk("R4 idx", 32'(txIdx), 2);
    chk("R4 flags", 32'(emptyFlags), 32'h3);

    // R6 lock holds against a better candidate
    pulseWin();
    flagClr(3'b001);
    chk("R6 locked idx", 32'(txIdx), 2);

    // R8 completion, R9 next offered at once
    timeIn = 16'h1234;
    pulseDone();
    chk("R8 done pulse", 32'(txDone), 32'h4);
    chk("R8 flag set", 32'(emptyFlags), 32'h6);
    chk("R9 next offered", 32'(txIdx), 0);
    chk("R9 req held", 32'(txReq), 1);
    cyc();
    chk("R8 pulse one cycle", 32'(txDone), 0);
    selWrite(3'b100);
    winRead(4'd14, rd);
    chk("R8 ts high", 32'(rd), 32'h12);
    winRead(4'd15, rd);
    chk("R8 ts low", 32'(rd), 32'h34);
    winWrite(4'd14, 8'hFF);
    winRead(4'd14, rd);
    chk("R3 ts write ignored", 32'(rd), 32'h12);

    // R11 selection drops a buffer made ready
    flagClr(3'b100);
    chk("R11 sel readback", 32'(selRd), 0);
    winRead(4'd0, rd);
    chk("R11 window empty", 32'(rd), 0);

    // R7 lost arbitration: buf0 locked, buf1 becomes better, lost
    selWrite(3'b010); winWrite(4'd13, 8'd1);
    pulseWin();
    chk("R7 locked buf0", 32'(txIdx), 0);
    flagClr(3'b010);
    chk("R7 still buf0", 32'(txIdx), 0);
    pulseLost();
    chk("R7 rearbitrated", 32'(txIdx), 1);
    chk("R7 buf0 pending", 32'(emptyFlags), 0);

    // R10 events with no lock
    pulseDone();
    chk("R10 done ignored flags", 32'(emptyFlags), 0);
    chk("R10 done ignored pulse", 32'(txDone), 0);
    pulseLost();
    chk("R10 lost ignored", 32'(txIdx), 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule